// File: doc/BRIEF.md
# Predicate-count saturating vector incrementer

This datapath adds one shared increment to every element of a wide vector operand. The increment is not an immediate. It is the number of active predicate elements, counted at the element size that a 2-bit size code selects. Each sum is treated as a signed integer and is clamped to the largest positive value the element can hold. The predicate carries one bit per vector byte. For each element, only the bit of that element's lowest byte decides whether the element counts.

The block works in place: the result replaces the vector operand in the surrounding datapath. Its latency is one clock. A small output state machine has three states. `ST_IDLE` means no result is presented. `ST_EMIT` means a legal request was taken and `out_vec` is valid. `ST_REJECT` means the size code was illegal. The state on each edge depends only on the request just sampled: IDLE→any, EMIT→any and REJECT→any transitions are taken on `in_valid` (legal code → EMIT, code 00 → REJECT, no request → IDLE).

Top module: `predcount_sat_inc`

## Requirements
- R1: The size code selects the element width: code 01 gives 16 bits, 10 gives 32 bits and 11 gives 64 bits. Lane e occupies bits [e*EW +: EW] of the vector, so the lane count is VEC_W/EW.
- R2: A request with size code 00 gives, on the next cycle, `out_illegal`=1 and `out_valid`=0, and leaves `out_vec` unchanged.
- R3: Element e is active when predicate bit e*(EW/8) is 1. All other predicate bits have no effect on the result.
- R4: The increment equals the number of active elements. It is added to every lane, active or not.
- R5: Sums above 2^(EW-1)-1 are clamped to that value. Negative lanes are incremented without wrap, so a lane at the minimum value becomes minimum plus the count.
- R6: `out_valid` is 1 exactly in the cycle after a request with a legal size code. `out_valid` and `out_illegal` are both 0 after a cycle with no request.
- R7: A synchronous active-high reset clears `out_valid`, `out_illegal` and `out_vec` to zero.
- R8: With no active elements, the result equals the input vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| in_size | input | 2 | Element size code (00 illegal, 01/10/11 = 16/32/64 bits) |
| in_vec | input | VEC_W | Vector operand |
| in_pred | input | VEC_W/8 | Predicate, one bit per byte |
| out_valid | output | 1 | Result valid, one cycle after a legal request |
| out_illegal | output | 1 | Size code 00 was requested in the previous cycle |
| out_vec | output | VEC_W | Saturated result vector |

## Verification
Assertions run on every cycle. They check the following:
- the one-cycle timing of `out_valid` and `out_illegal`;
- that a rejected request leaves the result register untouched;
- that the reset state is correct;
- that no lane ever comes out below its input;
- that the active count never exceeds the lane count of the chosen size.

The bench scenarios are what show the exact values. These are:
- the count for each size, including predicates that have only non-lead bits set;
- lane placement;
- the clamp at and just below the positive limit;
- the unwrapped increment of negative lanes.

// File: rtl/pcsi_pkg.sv
package pcsi_pkg;

    typedef enum logic [1:0] {
        SZ_BAD = 2'b00,
        SZ_H16 = 2'b01,
        SZ_W32 = 2'b10,
        SZ_D64 = 2'b11
    } esize_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_EMIT   = 2'b01,
        ST_REJECT = 2'b10
    } ostate_e;

    function automatic int unsigned elem_bits(input int unsigned code);
        return 8 << code;
    endfunction

endpackage

// File: rtl/pcsi_elem_count.sv
module pcsi_elem_count #(
    parameter int VEC_W = 256,
    parameter int CNT_W = 5
) (
    input  logic [VEC_W/8-1:0] pred,
    input  logic [1:0]         size,
    output logic [CNT_W-1:0]   count
);
    localparam int PRED_W = VEC_W / 8;

    logic [CNT_W-1:0] cnt_sz [4];

    // Per-size popcount of the lead predicate bit of each element
    for (genvar g = 0; g < 4; g++) begin : g_size
        if (g == 0) begin : g_bad
            assign cnt_sz[g] = '0;
        end else begin : g_legal
            localparam int STEP = 1 << g;
            localparam int NEL  = PRED_W / STEP;
            logic [CNT_W-1:0] acc;
            always_comb begin
                acc = '0;
                for (int i = 0; i < NEL; i++) begin
                    acc = acc + CNT_W'(pred[i*STEP]);
                end
            end
            assign cnt_sz[g] = acc;
        end
    end

    logic unused_pred;
    assign unused_pred = ^pred;

    assign count = cnt_sz[size];

    // R4: count never exceeds the number of elements of the chosen size
    always_comb begin
        a_r4_count_bound: assert (int'(count) <= (VEC_W / (8 << size)))
            else $error("R4: active count %0d above lane count", count);
    end

endmodule

// File: rtl/pcsi_sat_lane.sv
module pcsi_sat_lane #(
    parameter int EW    = 16,
    parameter int CNT_W = 5
) (
    input  logic [EW-1:0]    elem,
    input  logic [CNT_W-1:0] inc,
    output logic [EW-1:0]    res
);
    localparam int WW = EW + 1;
    localparam logic [EW-1:0] POS_MAX = {1'b0, {(EW-1){1'b1}}};

    logic [WW-1:0] wide;
    logic          ovf;

    always_comb begin
        wide = {elem[EW-1], elem} + WW'(inc);
        ovf  = wide[EW] != wide[EW-1];
        res  = ovf ? POS_MAX : wide[EW-1:0];
    end

    // R5: adding a non-negative count never lowers a lane
    always_comb begin
        a_r5_never_below: assert ($signed(res) >= $signed(elem))
            else $error("R5: lane decreased");
    end

endmodule

// File: rtl/pcsi_vec_sat.sv
module pcsi_vec_sat #(
    parameter int VEC_W = 256,
    parameter int CNT_W = 5
) (
    input  logic [VEC_W-1:0] vec,
    input  logic [CNT_W-1:0] inc,
    input  logic [1:0]       size,
    output logic [VEC_W-1:0] res
);
    logic [VEC_W-1:0] res_sz [4];

    for (genvar g = 0; g < 4; g++) begin : g_size
        if (g == 0) begin : g_bad
            assign res_sz[g] = vec;
        end else begin : g_legal
            localparam int EW = 8 << g;
            localparam int NL = VEC_W / EW;
            logic [VEC_W-1:0] lanes_out;
            for (genvar l = 0; l < NL; l++) begin : g_lane
                pcsi_sat_lane #(.EW(EW), .CNT_W(CNT_W)) i_lane (
                    .elem (vec[l*EW +: EW]),
                    .inc  (inc),
                    .res  (lanes_out[l*EW +: EW])
                );
            end
            assign res_sz[g] = lanes_out;
        end
    end

    assign res = res_sz[size];

endmodule

// File: rtl/predcount_sat_inc.sv
module predcount_sat_inc
    import pcsi_pkg::*;
#(
    parameter int VEC_W = 256
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [1:0]         in_size,
    input  logic [VEC_W-1:0]   in_vec,
    input  logic [VEC_W/8-1:0] in_pred,
    output logic               out_valid,
    output logic               out_illegal,
    output logic [VEC_W-1:0]   out_vec
);
    localparam int MAX_EL = VEC_W / 16;
    localparam int CNT_W  = $clog2(MAX_EL + 1);

    ostate_e          st_q, st_d;
    logic [CNT_W-1:0] act_cnt;
    logic [VEC_W-1:0] sat_vec;
    logic [VEC_W-1:0] vec_q;
    logic             legal;

    assign legal = in_size != SZ_BAD;

    pcsi_elem_count #(.VEC_W(VEC_W), .CNT_W(CNT_W)) i_count (
        .pred  (in_pred),
        .size  (in_size),
        .count (act_cnt)
    );

    pcsi_vec_sat #(.VEC_W(VEC_W), .CNT_W(CNT_W)) i_sat (
        .vec  (in_vec),
        .inc  (act_cnt),
        .size (in_size),
        .res  (sat_vec)
    );

    // Next state from the request just sampled
    always_comb begin
        st_d = ST_IDLE;
        if (in_valid) begin
            st_d = legal ? ST_EMIT : ST_REJECT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q <= '0;
        end else if (in_valid && legal) begin
            vec_q <= sat_vec;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        out_valid   = 1'b0;
        out_illegal = 1'b0;
        unique case (st_q)
            ST_IDLE:   ;
            ST_EMIT:   out_valid   = 1'b1;
            ST_REJECT: out_illegal = 1'b1;
            default:   ;
        endcase
    end

    assign out_vec = vec_q;

    // R6: a legal request yields a valid result one cycle later
    a_r6_emit_next: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_size != 2'b00) |=> (out_valid && !out_illegal));

    // R2: an illegal code flags, gives no result and keeps the data
    a_r2_reject_next: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_size == 2'b00) |=> (out_illegal && !out_valid && $stable(out_vec)));

    // R6: no request, no output strobe
    a_r6_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_illegal));

    // R7: reset clears the outputs
    a_r7_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_illegal && out_vec == '0));

endmodule

// File: tb/test_predcount_sat_inc.sv
module test_predcount_sat_inc;
    localparam int TB_W = 128;
    localparam int PW   = TB_W / 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [1:0]      in_size = 2'b01;
    logic [TB_W-1:0] in_vec = '0;
    logic [PW-1:0]   in_pred = '0;
    logic            out_valid;
    logic            out_illegal;
    logic [TB_W-1:0] out_vec;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    predcount_sat_inc #(.VEC_W(TB_W)) i_predcount_sat_inc (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_size(in_size),
        .in_vec(in_vec), .in_pred(in_pred), .out_valid(out_valid),
        .out_illegal(out_illegal), .out_vec(out_vec)
    );

    function automatic logic [TB_W-1:0] exp_vec(input logic [TB_W-1:0] v,
                                                 input logic [PW-1:0] p, input int sz);
        int ew = 8 << sz;
        int nl = TB_W / ew;
        int cnt = 0;
        logic signed [127:0] one = 128'sd1;
        logic [127:0] mask = (128'd1 << ew) - 128'd1;
        logic [TB_W-1:0] r = '0;
        for (int e = 0; e < nl; e++) if (p[e*(ew/8)]) cnt++;
        for (int l = 0; l < nl; l++) begin
            logic [127:0] raw = (128'(v) >> (l*ew)) & mask;
            logic signed [127:0] s = $signed(raw);
            logic signed [127:0] smax = (one <<< (ew-1)) - one;
            if (raw[ew-1]) s = s - (one <<< ew);
            s = s + cnt;
            if (s > smax) s = smax;
            r = r | TB_W'((128'(s) & mask) << (l*ew));
        end
        return r;
    endfunction

    function automatic logic [PW-1:0] lead_bits(input int sz);
        logic [PW-1:0] m = '0;
        for (int i = 0; i < PW; i += (1 << sz)) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [TB_W-1:0] fill(input int sz, input logic [63:0] val);
        int ew = 8 << sz;
        logic [TB_W-1:0] r = '0;
        logic [127:0] mask = (128'd1 << ew) - 128'd1;
        for (int l = 0; l < TB_W/ew; l++) r = r | TB_W'((128'(val) & mask) << (l*ew));
        return r;
    endfunction

    function automatic logic [63:0] posmax(input int sz);
        return 64'((128'd1 << ((8 << sz) - 1)) - 128'd1);
    endfunction

    task automatic chk(input string tag, input logic ok, input logic [TB_W-1:0] got,
                       input logic [TB_W-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic [TB_W-1:0] v, input logic [PW-1:0] p,
                         input logic [1:0] sz, input string tag);
        logic [TB_W-1:0] prev = out_vec;
        logic [TB_W-1:0] e;
        in_valid = 1'b1; in_vec = v; in_pred = p; in_size = sz;
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        if (sz == 2'b00) begin
            chk("R2 illegal flag", out_illegal && !out_valid, TB_W'({out_illegal, out_valid}), TB_W'(2'b10));
            chk("R2 data held", out_vec == prev, out_vec, prev);
        end else begin
            e = exp_vec(v, p, sz);
            chk(tag, out_vec == e, out_vec, e);
            chk("R6 valid next cycle", out_valid && !out_illegal, TB_W'({out_illegal, out_valid}), TB_W'(2'b01));
        end
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL R6 watchdog expired: actual hang expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7 reset state", !out_valid && !out_illegal && out_vec == '0, out_vec, '0);
        rst = 1'b0;

        // R1: lane placement, 16-bit lanes, only lane 0 active -> every lane 1
        apply('0, PW'(1), 2'b01, "R1 lane layout");
        chk("R1 each lane one", out_vec == {8{16'h0001}}, out_vec, {8{16'h0001}});

        for (int sz = 1; sz <= 3; sz++) begin
            logic [63:0] mx = posmax(sz);
            int nl = TB_W / (8 << sz);
            // R8: no active elements
            apply({$urandom, $urandom, $urandom, $urandom}, '0, 2'(sz), "R8 all-false unchanged");
            // R3: only non-lead bits set -> no count
            if (sz > 0)
                apply({$urandom, $urandom, $urandom, $urandom}, ~lead_bits(sz), 2'(sz), "R3 non-lead ignored");
            // R4: all true
            apply({$urandom, $urandom, $urandom, $urandom}, '1, 2'(sz), "R4 all-true");
            // R4: count sweep, first n elements active
            for (int n = 0; n <= nl; n++) begin
                logic [PW-1:0] p = '0;
                for (int e = 0; e < n; e++) p[e*(1 << sz)] = 1'b1;
                apply(fill(sz, 64'd5), p, 2'(sz), "R4 count sweep");
            end
            // R5: lanes at maximum and near it
            apply(fill(sz, mx), '1, 2'(sz), "R5 at max");
            for (int k = 0; k <= nl + 1; k++)
                apply(fill(sz, mx - 64'(k)), '1, 2'(sz), "R5 near max");
            // R5: negative lanes
            apply(fill(sz, mx + 64'd1), '1, 2'(sz), "R5 min no wrap");
            apply(fill(sz, '1), '1, 2'(sz), "R5 minus one");
            // R4: random mix
            for (int it = 0; it < 30; it++) begin
                logic [TB_W-1:0] v = {$urandom, $urandom, $urandom, $urandom};
                if (it % 3 == 0) v = v | fill(sz, mx - 64'd3);
                apply(v, PW'($urandom), 2'(sz), "R4 random");
            end
        end

        // R2: illegal code
        apply(fill(1, 64'h1234), '1, 2'b00, "R2");
        apply(fill(1, 64'h7777), '1, 2'b00, "R2");

        // R6: idle cycle drops strobes
        @(posedge clk); @(negedge clk);
        chk("R6 quiet after idle", !out_valid && !out_illegal, TB_W'({out_illegal, out_valid}), '0);

        // R7: reset again clears data
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R7 reset clears", !out_valid && !out_illegal && out_vec == '0, out_vec, '0);
        rst = 1'b0;

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule